// File: doc/BRIEF.md
# SECDED Protected Register File

This block is a small register file of 32 words, 32 bits each, in which every stored word is guarded by an extended Hamming code. This code corrects any single flipped bit and detects any two flipped bits. A write encodes the incoming word into a 39-bit codeword and stores it in the indexed entry. A read decodes the indexed codeword and returns the data one clock later, together with a status. The status says whether the word came back untouched, came back after a single-bit repair, or could not be trusted.

A test-only injection port XORs a mask into one stored codeword, so that upsets can be produced on demand. Repairs made on a read are not written back to storage. A stored error therefore stays in place until the entry is overwritten. Three or more flipped bits in one entry are outside what the code can judge reliably.

Top module: `ecc_regfile`

## Requirements
- R1: A write stores `wr_data_i` into entry `idx_i`. A later read of that entry with no injection in between returns the same data with status 2'b00 (clean).
- R2: `rd_data_o` and `rd_status_o` are registered. They take new values on the first clock edge after `rd_en_i` is sampled high, and they hold their values in every cycle in which `rd_en_i` is low.
- R3: A synchronous reset sets every entry to the all-zero codeword, which is the encoding of the word 0. It also sets `rd_data_o` to 0 and `rd_status_o` to 2'b00.
- R4: Codeword layout. Bit i of the 39-bit codeword holds position i+1. Hamming parity occupies positions 1, 2, 4, 8, 16 and 32. Data bits fill positions 3 to 38 that are not powers of two, in ascending order with data bit 0 lowest. Position 39 (bit 38) holds the even parity of positions 1 to 38. Bit i of `inj_mask_i` flips codeword bit i.
- R5: A single flipped bit at any of the 39 positions, including the overall parity bit, is repaired. The read returns the original data with status 2'b01 (corrected).
- R6: Two flipped bits in one entry give status 2'b10 (uncorrectable). An odd error whose syndrome points beyond position 38 also gives status 2'b10.
- R7: A correction on read leaves storage unchanged. Reading the same corrupted entry again reports 2'b01 again, until the entry is rewritten.
- R8: When a read and a write address the same entry in the same cycle, the read returns the contents held before that write.
- R9: An injection on the entry being written in the same cycle is discarded, and the write wins. An injection on the entry being read in the same cycle is not seen by that read, but it is seen by the next read.
- R10: `rd_status_o` never takes the value 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| idx_i | input | 5 | Entry index for both read and write |
| wr_data_i | input | 32 | Word to store |
| inj_en_i | input | 1 | Apply the injection mask this cycle |
| inj_idx_i | input | 5 | Entry that receives the injection |
| inj_mask_i | input | 39 | Codeword bits to flip |
| rd_data_o | output | 32 | Decoded read word |
| rd_status_o | output | 2 | 00 clean, 01 corrected, 10 uncorrectable |

## Verification
Upset injection and normal traffic can meet in one cycle. The bench provokes this by pulsing the injection port on the same edge as a write to that entry, and separately on the same edge as a read of it. It judges the first case by the write's data coming back clean. It judges the second case by the same-cycle read being clean while the following read reports a correction. A read and a write of the same index in one cycle are also driven together, and the read must return the older word.

// File: rtl/ecc_rf_pkg.sv
package ecc_rf_pkg;

    typedef enum logic [1:0] {
        ST_CLEAN = 2'b00,
        ST_FIXED = 2'b01,
        ST_BAD   = 2'b10
    } rd_status_e;

    // Smallest parity count p with 2**p >= data + p + 1.
    function automatic int par_bits(input int dw);
        int res;
        res = 0;
        for (int p = 12; p >= 1; p--) begin
            if ((1 << p) >= dw + p + 1) res = p;
        end
        return res;
    endfunction

    // Codeword position (1-based) that holds data bit j.
    function automatic int data_pos(input int j);
        int res;
        int cnt;
        res = 0;
        cnt = 0;
        for (int q = 3; q < 1024; q++) begin
            if ((q & (q - 1)) != 0) begin
                if (cnt == j) res = q;
                cnt++;
            end
        end
        return res;
    endfunction

endpackage

// File: rtl/ecc_rf_encoder.sv
module ecc_rf_encoder #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0]                                  data_i,
    output logic [DATA_W+ecc_rf_pkg::par_bits(DATA_W):0]       cw_o
);
    localparam int PAR_W = ecc_rf_pkg::par_bits(DATA_W);
    localparam int HAM_W = DATA_W + PAR_W;

    function automatic logic [DATA_W-1:0] cover_mask(input int k);
        logic [DATA_W-1:0] m;
        m = '0;
        for (int j = 0; j < DATA_W; j++) begin
            m[j] = ((ecc_rf_pkg::data_pos(j) >> k) & 1) != 0;
        end
        return m;
    endfunction

    logic [HAM_W-1:0] ham;

    for (genvar j = 0; j < DATA_W; j++) begin : g_data
        localparam int P = ecc_rf_pkg::data_pos(j);
        assign ham[P-1] = data_i[j];
    end

    for (genvar k = 0; k < PAR_W; k++) begin : g_par
        localparam logic [DATA_W-1:0] COVER = cover_mask(k);
        assign ham[(1 << k) - 1] = ^(data_i & COVER);
    end

    assign cw_o = {^ham, ham};

endmodule

// File: rtl/ecc_rf_decoder.sv
module ecc_rf_decoder #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W+ecc_rf_pkg::par_bits(DATA_W):0] cw_i,
    output logic [DATA_W-1:0]                            data_o,
    output ecc_rf_pkg::rd_status_e                       status_o
);
    import ecc_rf_pkg::*;

    localparam int PAR_W = par_bits(DATA_W);
    localparam int HAM_W = DATA_W + PAR_W;

    function automatic logic [HAM_W-1:0] pos_mask(input int k);
        logic [HAM_W-1:0] m;
        m = '0;
        for (int pos = 1; pos <= HAM_W; pos++) begin
            m[pos-1] = ((pos >> k) & 1) != 0;
        end
        return m;
    endfunction

    logic [PAR_W-1:0] syn;
    logic             par_err;
    logic [HAM_W-1:0] flip;
    logic [HAM_W-1:0] fixed;

    for (genvar k = 0; k < PAR_W; k++) begin : g_syn
        localparam logic [HAM_W-1:0] PMASK = pos_mask(k);
        assign syn[k] = ^(cw_i[HAM_W-1:0] & PMASK);
    end

    assign par_err = ^cw_i;

    always_comb begin
        flip     = '0;
        status_o = ST_CLEAN;
        if (par_err) begin
            if (syn == '0) begin
                status_o = ST_FIXED;      // overall parity bit itself flipped
            end else if (int'(syn) <= HAM_W) begin
                for (int pos = 1; pos <= HAM_W; pos++) begin
                    if (int'(syn) == pos) flip[pos-1] = 1'b1;
                end
                status_o = ST_FIXED;
            end else begin
                status_o = ST_BAD;        // odd error pointing outside the word
            end
        end else if (syn != '0) begin
            status_o = ST_BAD;            // even error count
        end
    end

    assign fixed = cw_i[HAM_W-1:0] ^ flip;

    for (genvar j = 0; j < DATA_W; j++) begin : g_ext
        localparam int P = data_pos(j);
        assign data_o[j] = fixed[P-1];
    end

endmodule

// File: rtl/ecc_rf_store.sv
module ecc_rf_store #(
    parameter int IDX_W = 5,
    parameter int CW_W  = 39
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             wr_en_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic [CW_W-1:0]  wr_cw_i,
    input  logic             inj_en_i,
    input  logic [IDX_W-1:0] inj_idx_i,
    input  logic [CW_W-1:0]  inj_mask_i,
    output logic [CW_W-1:0]  rd_cw_o
);
    localparam int DEPTH = 1 << IDX_W;

    typedef struct packed {
        logic [DEPTH-1:0][CW_W-1:0] mem;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (inj_en_i) begin
            st_d.mem[inj_idx_i] = st_q.mem[inj_idx_i] ^ inj_mask_i;
        end
        if (wr_en_i) begin
            st_d.mem[idx_i] = wr_cw_i;    // write overrides a same-entry injection
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;            // all-zero codeword encodes word 0
        else       st_q <= st_d;
    end

    assign rd_cw_o = st_q.mem[idx_i];

endmodule

// File: rtl/ecc_regfile.sv
module ecc_regfile #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 5
) (
    input  logic                                        clk_i,
    input  logic                                        rst_i,
    input  logic                                        wr_en_i,
    input  logic                                        rd_en_i,
    input  logic [IDX_W-1:0]                            idx_i,
    input  logic [DATA_W-1:0]                           wr_data_i,
    input  logic                                        inj_en_i,
    input  logic [IDX_W-1:0]                            inj_idx_i,
    input  logic [DATA_W+ecc_rf_pkg::par_bits(DATA_W):0] inj_mask_i,
    output logic [DATA_W-1:0]                           rd_data_o,
    output logic [1:0]                                  rd_status_o
);
    import ecc_rf_pkg::*;

    localparam int PAR_W = par_bits(DATA_W);
    localparam int CW_W  = DATA_W + PAR_W + 1;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        rd_status_e        status;
    } rd_out_t;

    logic [CW_W-1:0]   wr_cw;
    logic [CW_W-1:0]   rd_cw;
    logic [DATA_W-1:0] dec_data;
    rd_status_e        dec_status;
    rd_out_t           out_d, out_q;

    ecc_rf_encoder #(.DATA_W(DATA_W)) enc_i (
        .data_i (wr_data_i),
        .cw_o   (wr_cw)
    );

    ecc_rf_store #(.IDX_W(IDX_W), .CW_W(CW_W)) store_i (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .wr_en_i    (wr_en_i),
        .idx_i      (idx_i),
        .wr_cw_i    (wr_cw),
        .inj_en_i   (inj_en_i),
        .inj_idx_i  (inj_idx_i),
        .inj_mask_i (inj_mask_i),
        .rd_cw_o    (rd_cw)
    );

    ecc_rf_decoder #(.DATA_W(DATA_W)) dec_i (
        .cw_i     (rd_cw),
        .data_o   (dec_data),
        .status_o (dec_status)
    );

    always_comb begin
        out_d = out_q;
        if (rd_en_i) begin
            out_d.data   = dec_data;
            out_d.status = dec_status;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            out_q.data   <= '0;
            out_q.status <= ST_CLEAN;
        end else begin
            out_q <= out_d;
        end
    end

    assign rd_data_o   = out_q.data;
    assign rd_status_o = out_q.status;

endmodule

// File: rtl/ecc_regfile_chk.sv
module ecc_regfile_chk #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 5
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              wr_en_i,
    input logic              rd_en_i,
    input logic [IDX_W-1:0]  idx_i,
    input logic [DATA_W-1:0] wr_data_i,
    input logic              inj_en_i,
    input logic [IDX_W-1:0]  inj_idx_i,
    input logic [DATA_W-1:0] rd_data_o,
    input logic [1:0]        rd_status_o
);

    p_status_legal_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        rd_status_o != 2'b11);

    p_reset_state_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> (rd_data_o == '0 && rd_status_o == 2'b00));

    p_hold_idle_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i) && !$past(rd_en_i)) |-> ($stable(rd_data_o) && $stable(rd_status_o)));

    p_write_read_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_en_i && !(inj_en_i && inj_idx_i == idx_i)) |=>
        ((rd_en_i && !wr_en_i && idx_i == $past(idx_i)) |=>
         (rd_data_o == $past(wr_data_i, 2) && rd_status_o == 2'b00)));

endmodule

bind ecc_regfile ecc_regfile_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) chk_i (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .wr_en_i     (wr_en_i),
    .rd_en_i     (rd_en_i),
    .idx_i       (idx_i),
    .wr_data_i   (wr_data_i),
    .inj_en_i    (inj_en_i),
    .inj_idx_i   (inj_idx_i),
    .rd_data_o   (rd_data_o),
    .rd_status_o (rd_status_o)
);

// File: tb/ecc_regfile_tb_top.sv
`timescale 1ns/1ps
module ecc_regfile_tb_top;

    logic        clk_i = 1'b0;
    logic        rst_i = 1'b1;
    logic        wr_en_i = 1'b0;
    logic        rd_en_i = 1'b0;
    logic [4:0]  idx_i = '0;
    logic [31:0] wr_data_i = '0;
    logic        inj_en_i = 1'b0;
    logic [4:0]  inj_idx_i = '0;
    logic [38:0] inj_mask_i = '0;
    logic [31:0] rd_data_o;
    logic [1:0]  rd_status_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    localparam logic [1:0] S_CLEAN = 2'b00;
    localparam logic [1:0] S_FIXED = 2'b01;
    localparam logic [1:0] S_BAD   = 2'b10;

    always #2 clk_i = ~clk_i;

    ecc_regfile dut_i (
        .clk_i(clk_i), .rst_i(rst_i), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
        .idx_i(idx_i), .wr_data_i(wr_data_i), .inj_en_i(inj_en_i),
        .inj_idx_i(inj_idx_i), .inj_mask_i(inj_mask_i),
        .rd_data_o(rd_data_o), .rd_status_o(rd_status_o)
    );

    task automatic check(input string req, input bit use_data,
                         input logic [31:0] exp_d, input logic [1:0] exp_s);
        n_checks++;
        if ((use_data && rd_data_o !== exp_d) || rd_status_o !== exp_s || rd_status_o === 2'b11) begin
            n_fail++;
            $display("FAIL %s: data %h status %b, expected data %h status %b",
                     req, rd_data_o, rd_status_o, exp_d, exp_s);
        end
    endtask

    task automatic do_write(input logic [4:0] idx, input logic [31:0] d);
        @(negedge clk_i);
        wr_en_i = 1'b1; idx_i = idx; wr_data_i = d;
        @(negedge clk_i);
        wr_en_i = 1'b0;
    endtask

    task automatic do_inject(input logic [4:0] idx, input logic [38:0] m);
        @(negedge clk_i);
        inj_en_i = 1'b1; inj_idx_i = idx; inj_mask_i = m;
        @(negedge clk_i);
        inj_en_i = 1'b0;
    endtask

    task automatic do_read(input logic [4:0] idx, input string req, input bit use_data,
                           input logic [31:0] exp_d, input logic [1:0] exp_s);
        @(negedge clk_i);
        rd_en_i = 1'b1; idx_i = idx;
        @(negedge clk_i);
        rd_en_i = 1'b0;
        check(req, use_data, exp_d, exp_s);
    endtask

    task automatic t_reset_r3();
        check("R3 outputs after reset", 1, 32'h0, S_CLEAN);
        for (int i = 0; i < 32; i++) do_read(5'(i), "R3 entry cleared", 1, 32'h0, S_CLEAN);
    endtask

    task automatic t_write_read_r1();
        logic [31:0] pat [4] = '{32'hFFFF_FFFF, 32'hA5A5_5A5A, 32'h0000_0001, 32'h8000_0000};
        for (int i = 0; i < 32; i++) do_write(5'(i), pat[i % 4] ^ (32'h0101_0101 * i));
        for (int i = 0; i < 32; i++) do_read(5'(i), "R1 write then read", 1, pat[i % 4] ^ (32'h0101_0101 * i), S_CLEAN);
    endtask

    task automatic t_hold_r2();
        do_write(5'd3, 32'h1234_5678);
        do_read(5'd3, "R2 read value", 1, 32'h1234_5678, S_CLEAN);
        do_write(5'd3, 32'hDEAD_BEEF);
        do_inject(5'd3, 39'h3);
        repeat (3) @(negedge clk_i);
        check("R2 hold without read", 1, 32'h1234_5678, S_CLEAN);
        do_write(5'd3, 32'hDEAD_BEEF);
    endtask

    task automatic t_single_r5_r4();
        for (int b = 0; b < 39; b++) begin
            logic [31:0] d = 32'hC3A5_0F1E ^ (32'h1 << (b % 32));
            do_write(5'(b % 32), d);
            do_inject(5'(b % 32), 39'h1 << b);
            do_read(5'(b % 32), (b == 38) ? "R4 overall parity bit flip" : "R5 single flip", 1, d, S_FIXED);
        end
    endtask

    task automatic t_double_r6();
        for (int b = 0; b < 38; b++) begin
            do_write(5'd10, 32'h7E57_0000 | 32'(b));
            do_inject(5'd10, (39'h1 << b) | (39'h1 << (b + 1)));
            do_read(5'd10, "R6 double flip", 0, 32'h0, S_BAD);
        end
        do_write(5'd10, 32'h0);
        do_inject(5'd10, (39'h1 << 0) | (39'h1 << 38));
        do_read(5'd10, "R6 double flip with overall bit", 0, 32'h0, S_BAD);
        // positions 1,2,4 flipped: odd count, syndrome 7 is a data position -> miscorrect allowed
        // positions 32,2,4 (bits 31,1,3): syndrome 38 odd -> in range; positions 32,16,8 (bits 31,15,7): syndrome 56 > 38
        do_write(5'd11, 32'h0);
        do_inject(5'd11, (39'h1 << 31) | (39'h1 << 15) | (39'h1 << 7));
        do_read(5'd11, "R6 syndrome beyond word", 0, 32'h0, S_BAD);
    endtask

    task automatic t_no_writeback_r7();
        do_write(5'd9, 32'h0BAD_F00D);
        do_inject(5'd9, 39'h1 << 20);
        do_read(5'd9, "R7 first corrected read", 1, 32'h0BAD_F00D, S_FIXED);
        do_read(5'd9, "R7 error still stored", 1, 32'h0BAD_F00D, S_FIXED);
        do_write(5'd9, 32'h0BAD_F00D);
        do_read(5'd9, "R7 clean after rewrite", 1, 32'h0BAD_F00D, S_CLEAN);
    endtask

    task automatic t_same_cycle_rw_r8();
        do_write(5'd7, 32'hAAAA_0007);
        @(negedge clk_i);
        wr_en_i = 1'b1; rd_en_i = 1'b1; idx_i = 5'd7; wr_data_i = 32'h5555_0007;
        @(negedge clk_i);
        wr_en_i = 1'b0; rd_en_i = 1'b0;
        check("R8 read returns old word", 1, 32'hAAAA_0007, S_CLEAN);
        do_read(5'd7, "R8 new word stored", 1, 32'h5555_0007, S_CLEAN);
    endtask

    task automatic t_inject_collide_r9();
        do_write(5'd5, 32'h1111_1111);
        @(negedge clk_i);
        wr_en_i = 1'b1; idx_i = 5'd5; wr_data_i = 32'h2222_2222;
        inj_en_i = 1'b1; inj_idx_i = 5'd5; inj_mask_i = 39'h1 << 12;
        @(negedge clk_i);
        wr_en_i = 1'b0; inj_en_i = 1'b0;
        do_read(5'd5, "R9 write beats injection", 1, 32'h2222_2222, S_CLEAN);

        do_write(5'd6, 32'h3333_3333);
        @(negedge clk_i);
        rd_en_i = 1'b1; idx_i = 5'd6;
        inj_en_i = 1'b1; inj_idx_i = 5'd6; inj_mask_i = 39'h1 << 25;
        @(negedge clk_i);
        rd_en_i = 1'b0; inj_en_i = 1'b0;
        check("R9 same-cycle read before injection", 1, 32'h3333_3333, S_CLEAN);
        do_read(5'd6, "R9 injection seen next read", 1, 32'h3333_3333, S_FIXED);
    endtask

    initial begin
        repeat (3) @(negedge clk_i);
        rst_i = 1'b0;
        t_reset_r3();
        t_write_read_r1();
        t_hold_r2();
        t_single_r5_r4();
        t_double_r6();
        t_no_writeback_r7();
        t_same_cycle_rw_r8();
        t_inject_collide_r9();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk_i);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual hung, expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule